// File: doc/BRIEF.md
# Limit-Reload Interval Timer

A memory-mapped interval timer for periodic interrupts. A prescaler divides the system clock into coarse ticks, nominally one every 500 ns. Each tick advances a count field. The field sits at bits `TICK_W+8:9` of a 32-bit word, so one tick adds 0x200 to the word and the low nine bits always read as zero.

The count is compared against a programmable limit. When the next tick would bring the count to a nonzero limit, the count restarts from zero, a sticky reached flag is set and a level interrupt is raised. Software acknowledges the interrupt by reading the limit word. A limit of zero turns the timer into a free-running counter that wraps just below the field maximum and never interrupts.

A second limit word loads a new limit without disturbing the running count. It is used to stretch or shorten the current interval in flight. Access is through a single-cycle synchronous strobe port with word-only accesses. Word index `k` is at byte address `4k`, and the two low address bits are ignored.

Top module: `interval_timer`

## Requirements
- R1: After reset the limit, the count, the reached flag and `irq` are all zero, and the timer is counting.
- R2: With `CLK_PER_TICK = D`, the count field advances by one on the D-th rising edge after reset release and then every D edges. The counter word therefore rises by 0x200 per tick, and bits 8:0 and every bit between the field and bit 31 read as zero.
- R3: With a nonzero limit L, the tick that would bring the count to L sets it to zero instead. On that same edge it sets the reached flag (bit 31 of word 1) and drives `irq` high.
- R4: With a limit of zero, the count runs up to the field maximum minus one and then returns to zero. Neither the reached flag nor `irq` is ever set.
- R5: Writing word 0 stores write-data bits `TICK_W+8:9` as the limit (all other bits dropped), forces the count to zero and drives `irq` low on that edge. The reached flag is kept. This write wins over a tick or an expiry in the same cycle.
- R6: Writing word 2 stores the limit the same way but leaves the count running. If the count is already above the new limit, it runs on to the field maximum, wraps through zero with no event, and expires when it next reaches the limit.
- R7: Reading word 0 returns the limit in bits `TICK_W+8:9` and zero elsewhere. It clears the reached flag and `irq` on that edge, unless an expiry happens on the same edge, in which case both end up set.
- R8: Reading word 1 returns the count field with the reached flag in bit 31 and has no side effect.
- R9: Writes to word 1 and to word indices 3 and above change nothing. Reads of word 2 and of indices 3 and above return zero.
- R10: `rdata` is zero in every cycle where `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, deasserted in step with `clk` |
| rd_en | input | 1 | Read strobe; side effect taken at the rising edge; never high together with `wr_en` |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| addr | input | ADDR_W | Byte address; word index is `addr[ADDR_W-1:2]` |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` while `rd_en` is high |
| irq | output | 1 | Level interrupt, high from an expiry until a limit read or limit write |

## Verification
A stuck or misdirected prescaler shows up as a counter word that leads or lags the arithmetic model within one tick period. A wrong terminal compare appears as an early or late jump of `irq` and bit 31, at latest one full interval later. Lost acknowledge or priority logic leaves `irq` at the wrong level on the edge right after a limit read or write. The bench therefore compares `irq` every cycle and the counter word on nearly every cycle.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  // Bit where the tick count field starts inside the 32-bit words.
  localparam int unsigned CNT_LSB     = 9;
  // Bit of the counter word that carries the sticky reached flag.
  localparam int unsigned REACHED_BIT = 31;
  // Widest count field that fits below the reached flag.
  localparam int unsigned TICK_W_MAX  = REACHED_BIT - CNT_LSB;

  typedef enum logic [1:0] {
    SEL_LIMIT      = 2'd0,
    SEL_COUNT      = 2'd1,
    SEL_LIMIT_KEEP = 2'd2,
    SEL_NONE       = 2'd3
  } word_sel_e;
endpackage

// File: rtl/itmr_tick_gen.sv
module itmr_tick_gen #(
  parameter int unsigned DIV = 62
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_every_clk
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign tick_o    = 1'b1;
    end else begin : g_divider
      localparam int unsigned DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);

      logic [DW-1:0] div_q, div_d;

      always_comb begin
        tick_o = (div_q == LAST);
        div_d  = tick_o ? '0 : div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          div_q <= '0;
        end else begin
          div_q <= div_d;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/itmr_core.sv
module itmr_core #(
  parameter int unsigned TICK_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              lim_wr_i,
  input  logic              lim_keep_wr_i,
  input  logic              lim_rd_i,
  input  logic [TICK_W-1:0] lim_val_i,
  output logic [TICK_W-1:0] cnt_o,
  output logic [TICK_W-1:0] lim_o,
  output logic              reached_o,
  output logic              irq_o
);
  logic [TICK_W-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic [TICK_W-1:0] term, cnt_inc;
  logic              rch_q, rch_d, irq_q, irq_d;
  logic              hit, expire, upd_en;

  // Next-state logic
  always_comb begin
    term    = (lim_q == '0) ? '1 : lim_q;
    cnt_inc = cnt_q + 1'b1;
    hit     = tick_i && (cnt_inc == term);
    expire  = hit && (lim_q != '0);

    cnt_d = cnt_q;
    lim_d = lim_q;
    rch_d = rch_q;
    irq_d = irq_q;

    if (tick_i) begin
      cnt_d = hit ? '0 : cnt_inc;
    end
    if (lim_rd_i) begin
      rch_d = 1'b0;
      irq_d = 1'b0;
    end
    if (expire) begin
      rch_d = 1'b1;
      irq_d = 1'b1;
    end
    if (lim_keep_wr_i) begin
      lim_d = lim_val_i;
    end
    if (lim_wr_i) begin
      lim_d = lim_val_i;
      cnt_d = '0;
      irq_d = 1'b0;
      rch_d = rch_q;
    end

    upd_en = tick_i | lim_wr_i | lim_keep_wr_i | lim_rd_i;
  end

  // State registers with an explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
      rch_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      rch_q <= rch_d;
      irq_q <= irq_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign lim_o     = lim_q;
  assign reached_o = rch_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/itmr_regfile.sv
module itmr_regfile
  import itmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned TICK_W = 22
) (
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [TICK_W-1:0] cnt_i,
  input  logic [TICK_W-1:0] lim_i,
  input  logic              reached_i,
  output logic              lim_wr_o,
  output logic              lim_keep_wr_o,
  output logic              lim_rd_o,
  output logic [TICK_W-1:0] lim_val_o,
  output logic [31:0]       rdata_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  word_sel_e        sel;
  logic [31:0]      lim_word, cnt_word;
  logic [1:0]       unused_lo;
  logic [31:0]      unused_wd;

  always_comb begin
    idx       = addr_i[ADDR_W-1:2];
    unused_lo = addr_i[1:0];
    if (idx == IDX_W'(0)) begin
      sel = SEL_LIMIT;
    end else if (idx == IDX_W'(1)) begin
      sel = SEL_COUNT;
    end else if (idx == IDX_W'(2)) begin
      sel = SEL_LIMIT_KEEP;
    end else begin
      sel = SEL_NONE;
    end

    lim_wr_o      = wr_en_i && (sel == SEL_LIMIT);
    lim_keep_wr_o = wr_en_i && (sel == SEL_LIMIT_KEEP);
    lim_rd_o      = rd_en_i && !wr_en_i && (sel == SEL_LIMIT);
    lim_val_o     = wdata_i[CNT_LSB +: TICK_W];
    unused_wd     = wdata_i;

    lim_word = 32'(lim_i) << CNT_LSB;
    cnt_word = (32'(cnt_i) << CNT_LSB) | (32'(reached_i) << REACHED_BIT);

    rdata_o = '0;
    if (rd_en_i) begin
      case (sel)
        SEL_LIMIT: rdata_o = lim_word;
        SEL_COUNT: rdata_o = cnt_word;
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int unsigned CLK_PER_TICK = 62,
  parameter int unsigned TICK_W       = 22,
  parameter int unsigned ADDR_W       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  logic              tick_w;
  logic              lim_wr_w, lim_keep_wr_w, lim_rd_w;
  logic [TICK_W-1:0] lim_val_w, cnt_w, lim_w;
  logic              reached_w;

  itmr_tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  itmr_regfile #(.ADDR_W(ADDR_W), .TICK_W(TICK_W)) u_regs (
    .rd_en_i       (rd_en),
    .wr_en_i       (wr_en),
    .addr_i        (addr),
    .wdata_i       (wdata),
    .cnt_i         (cnt_w),
    .lim_i         (lim_w),
    .reached_i     (reached_w),
    .lim_wr_o      (lim_wr_w),
    .lim_keep_wr_o (lim_keep_wr_w),
    .lim_rd_o      (lim_rd_w),
    .lim_val_o     (lim_val_w),
    .rdata_o       (rdata)
  );

  itmr_core #(.TICK_W(TICK_W)) u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_w),
    .lim_wr_i      (lim_wr_w),
    .lim_keep_wr_i (lim_keep_wr_w),
    .lim_rd_i      (lim_rd_w),
    .lim_val_i     (lim_val_w),
    .cnt_o         (cnt_w),
    .lim_o         (lim_w),
    .reached_o     (reached_w),
    .irq_o         (irq)
  );
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk #(
  parameter int unsigned TICK_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              lim_wr,
  input logic              lim_rd,
  input logic [TICK_W-1:0] cnt,
  input logic [TICK_W-1:0] lim,
  input logic              reached,
  input logic              irq
);
  // R5
  lim_wr_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lim_wr |=> !irq);

  // R3
  irq_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(tick) && ($past(lim) != '0)));

  // R2
  cnt_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> ($past(tick) || $past(lim_wr)));

  // R7
  lim_read_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_rd && !tick) |=> (!irq && !reached));

  // R3
  irq_implies_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> reached);
endmodule

bind interval_timer itmr_chk #(.TICK_W(TICK_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick_w),
  .lim_wr  (lim_wr_w),
  .lim_rd  (lim_rd_w),
  .cnt     (cnt_w),
  .lim     (lim_w),
  .reached (reached_w),
  .irq     (irq)
);

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;
  localparam int DIV = 3;
  localparam int TW  = 5;
  localparam int AW  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  interval_timer #(.CLK_PER_TICK(DIV), .TICK_W(TW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd), .wr_en(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // Arithmetic model built from the requirements
  int          m_div;
  logic [TW-1:0] m_t, m_lim;
  logic        m_rch, m_irq;

  always @(posedge clk or negedge rst_n) begin
    logic tk, ev;
    logic [TW-1:0] nxt, term;
    int idx;
    if (!rst_n) begin
      m_div <= 0; m_t <= '0; m_lim <= '0; m_rch <= 1'b0; m_irq <= 1'b0;
    end else begin
      idx  = int'(addr >> 2);
      tk   = (m_div == DIV - 1);
      term = (m_lim == '0) ? '1 : m_lim;
      nxt  = m_t + 1'b1;
      ev   = tk && (nxt == term) && (m_lim != '0);
      m_div <= tk ? 0 : m_div + 1;
      if (wr && idx == 0) begin
        m_lim <= wdata[9 +: TW]; m_t <= '0; m_irq <= 1'b0;
      end else begin
        if (tk) m_t <= (nxt == term) ? '0 : nxt;
        if (wr && idx == 2) m_lim <= wdata[9 +: TW];
        if (ev) begin
          m_rch <= 1'b1; m_irq <= 1'b1;
        end else if (rd && idx == 0) begin
          m_rch <= 1'b0; m_irq <= 1'b0;
        end
      end
    end
  end

  function automatic logic [31:0] rexp(int idx);
    if (idx == 0) return 32'(m_lim) << 9;
    if (idx == 1) return {m_rch, 31'b0} | (32'(m_t) << 9);
    return 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  // irq every cycle (R3, R4), idle read data (R10)
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R3 irq level", 32'(irq), 32'(m_irq));
      if (!rd) chk("R10 idle rdata", rdata, 32'h0);
    end
  end

  // Tasks drive at a falling edge and return at the next one
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      rd = 0; wr = 0; @(negedge clk);
    end
  endtask

  task automatic wr_w(int idx, logic [31:0] v);
    rd = 0; wr = 1; addr = AW'(idx * 4); wdata = v;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rd_w(int idx, string tag);
    wr = 0; rd = 1; addr = AW'(idx * 4);
    #2; chk(tag, rdata, rexp(idx));
    @(negedge clk);
    rd = 0;
  endtask

  task automatic watch_count(int n, string tag);
    for (int i = 0; i < n; i++) rd_w(1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd_w(0, "R1 limit after reset");
    rd_w(1, "R1 count after reset");
    // R2, R4: free run through a full wrap
    watch_count((1 << TW) * DIV + 12, "R4 free-run count");
    // R3, R5, R7: interval sweep
    for (int L = 1; L < 8; L++) begin
      wr_w(0, 32'(L) << 9);
      rd_w(0, "R5 limit readback");
      watch_count(3 * L * DIV + 2, "R3 interval count");
      rd_w(0, "R7 limit read ack");
      idle(2);
    end
    // R5: masking of write data
    wr_w(0, 32'hFFFF_FFFF);
    rd_w(0, "R5 limit masked");
    rd_w(1, "R8 count word");
    // R6: keep-count limit update, above and below current count
    wr_w(0, 32'd20 << 9);
    idle(12 * DIV);
    wr_w(2, 32'd25 << 9);
    watch_count(16 * DIV, "R6 extend interval");
    while (m_t < 10) idle(1);
    wr_w(2, 32'd4 << 9);
    rd_w(0, "R6 limit stored");
    watch_count(40 * DIV, "R6 wrap past limit");
    // R5: limit write in the same cycle as a tick
    while (m_div != DIV - 1) idle(1);
    wr_w(0, 32'd3 << 9);
    rd_w(1, "R5 write beats tick");
    // R7: acknowledge read racing an expiry
    while (!(m_div == DIV - 1 && TW'(m_t + 1) == m_lim)) idle(1);
    rd_w(0, "R7 read at expiry");
    rd_w(1, "R7 reached survives race");
    rd_w(0, "R7 second ack");
    rd_w(1, "R7 reached cleared");
    // R9: ignored writes and zero reads
    wr_w(1, 32'h1234_5600);
    rd_w(1, "R9 count write ignored");
    wr_w(5, 32'h0000_0600);
    wr_w(7, 32'hFFFF_FFFF);
    rd_w(0, "R9 limit unchanged");
    rd_w(2, "R9 word2 reads zero");
    rd_w(3, "R9 word3 reads zero");
    rd_w(7, "R9 word7 reads zero");
    idle(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule